// File: doc/BRIEF.md
# Unified CORDIC Rotation Engine

This block evaluates elementary functions with an iterative shift-and-add rotation datapath. A single recurrence, steered by a coordinate factor of +1 or −1, produces cosine and sine of an angle (circular mode), or hyperbolic cosine and sine of an argument (hyperbolic mode). The third output is always the sum of the other two, so in hyperbolic mode it is e^x. The X register starts at the inverse of the mode's aggregate gain and Y starts at zero, so no scaling is needed at the end.

The angle is an unsigned fraction of a full turn. It is folded into the range −90°..+90° before iterating, and the circular results are negated afterwards when the fold moved the angle by half a turn. The hyperbolic argument is unsigned with two integer bits. Hyperbolic iterations begin at shift 1, and shifts 4 and 13 are each executed twice so that the recurrence converges. The arctangent and inverse hyperbolic tangent step tables are computed from series when the design is elaborated.

A caller pulses `start_i` with the mode and argument. The result appears a fixed number of cycles later together with a one-cycle `done_o`. The results then hold until the next completion.

Top module: `cordic_rot_engine`

## Requirements
- R1: In circular mode (`mode_i`=0), `x_o` = cos(2π·a) and `y_o` = sin(2π·a), where a = `angle_i`/2^32. Each error is within 2e-4. Outputs are signed two's complement, 34 bits, 30 fraction bits.
- R2: R1 holds for every quadrant, including the boundary angles 90° (0x40000000), 180° (0x80000000) and 270° (0xC0000000).
- R3: In hyperbolic mode (`mode_i`=1), `x_o` = cosh(h) and `y_o` = sinh(h) within 2e-4, where h = `hyp_arg_i`/2^30 and 0 ≤ h ≤ 1.0.
- R4: `sum_o` equals `x_o` + `y_o`. In hyperbolic mode it therefore gives e^h within 4e-4.
- R5: In circular mode `done_o` rises exactly ITERS+1 clock edges after the edge that accepted the start (17 by default).
- R6: In hyperbolic mode `done_o` rises exactly ITERS+3 edges after the accepting edge (19 by default, which includes the two repeated shifts).
- R7: `done_o` is high for exactly one cycle per accepted start.
- R8: `x_o`, `y_o` and `sum_o` change only in the cycle where `done_o` is high. In every other cycle they hold, whatever the inputs do.
- R9: A `start_i` that arrives while a computation is running is ignored. The running result and its timing are unaffected.
- R10: While `rst_ni` is low, `done_o` is 0 and `x_o`, `y_o` and `sum_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a computation when idle |
| mode_i | input | 1 | 0 circular, 1 hyperbolic |
| angle_i | input | 32 | Unsigned fraction of a full turn |
| hyp_arg_i | input | 32 | Unsigned hyperbolic argument, 30 fraction bits |
| x_o | output | 34 | cos or cosh, signed, 30 fraction bits |
| y_o | output | 34 | sin or sinh, signed, 30 fraction bits |
| sum_o | output | 34 | x_o + y_o (exp in hyperbolic mode) |
| done_o | output | 1 | One-cycle result strobe |

## Verification
The assertions check, on every cycle, the items below:
- the exact completion latency for each mode, counted from the accepting edge;
- the single-cycle width of the done strobe;
- that the outputs are frozen outside completion cycles;
- coarse range bounds on the results: circular results stay within ±1, and cosh never falls below 1.

Only the bench's scenarios can show the items below:
- numerical accuracy across quadrants and the fold boundaries;
- the hyperbolic and exponential values;
- that a start during a running computation leaves its result untouched.

// File: rtl/cordic_pkg.sv
package cordic_pkg;
  localparam int ANG_W = 32;
  localparam int W     = 34;
  localparam int FRAC  = 30;

  typedef logic signed [W-1:0] dat_t;

  // inverse gains, Q.30 then scaled to FRAC
  localparam dat_t GAIN_C = dat_t'(34'sd652032874)  <<< (FRAC - 30);
  localparam dat_t GAIN_H = dat_t'(34'sd1296540104) <<< (FRAC - 30);
  // 2*pi with 28 fraction bits
  localparam logic signed [31:0] TWO_PI_Q28 = 32'sh6487ED51;

  function automatic bit is_rep(int s);
    int k;
    k = 4;
    for (int n = 0; n < 8; n++) begin
      if (k == s) return 1'b1;
      k = 3 * k + 1;
    end
    return 1'b0;
  endfunction

  function automatic int rep_count(int n);
    int c;
    c = 0;
    for (int s = 1; s <= n; s++) if (is_rep(s)) c++;
    return c;
  endfunction

  // atan(2^-i) or atanh(2^-i) with 60 fraction bits, by power series
  function automatic logic signed [63:0] arc_q60(int i, bit hyp);
    logic signed [63:0] term, acc;
    acc = '0;
    if (i == 0) begin
      acc = hyp ? 64'sd0 : 64'sh0C90FDAA22168C23;
    end else begin
      term = 64'sd1 <<< (60 - i);
      for (int k = 0; k < 24; k++) begin
        if (hyp || (k % 2 == 0)) acc = acc + term / 64'(2 * k + 1);
        else                     acc = acc - term / 64'(2 * k + 1);
        term = term >>> (2 * i);
      end
    end
    return acc;
  endfunction
endpackage

// File: rtl/cordic_arg_prep.sv
module cordic_arg_prep
  import cordic_pkg::*;
(
  input  logic             mode_i,
  input  logic [ANG_W-1:0] angle_i,
  input  logic [ANG_W-1:0] hyp_arg_i,
  output dat_t             x0_o,
  output dat_t             z0_o,
  output logic             flip_o
);
  logic signed [ANG_W-1:0]   turn_s;
  logic signed [2*ANG_W-1:0] prod;

  // quadrants 1 and 2 move by half a turn; bit 30 becomes the new sign
  always_comb begin
    turn_s = {angle_i[ANG_W-2], angle_i[ANG_W-2:0]};
    prod   = 64'(turn_s) * 64'(TWO_PI_Q28);
    if (mode_i) begin
      x0_o   = GAIN_H;
      z0_o   = dat_t'(hyp_arg_i) <<< (FRAC - 30);
      flip_o = 1'b0;
    end else begin
      x0_o   = GAIN_C;
      z0_o   = dat_t'(prod >>> (60 - FRAC));
      flip_o = angle_i[ANG_W-1] ^ angle_i[ANG_W-2];
    end
  end
endmodule

// File: rtl/cordic_arc_rom.sv
module cordic_arc_rom
  import cordic_pkg::*;
#(
  parameter int DEPTH = 17,
  parameter int SHW   = 5
) (
  input  logic [SHW-1:0] sh_i,
  input  logic           hyp_i,
  output dat_t           dz_o
);
  dat_t circ_tbl [DEPTH];
  dat_t hyp_tbl  [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    assign circ_tbl[g] = dat_t'(arc_q60(g, 1'b0) >>> (60 - FRAC));
    assign hyp_tbl[g]  = dat_t'(arc_q60(g, 1'b1) >>> (60 - FRAC));
  end

  assign dz_o = hyp_i ? hyp_tbl[sh_i] : circ_tbl[sh_i];
endmodule

// File: rtl/cordic_step.sv
module cordic_step
  import cordic_pkg::*;
#(
  parameter int SHW = 5
) (
  input  dat_t           x_i,
  input  dat_t           y_i,
  input  dat_t           z_i,
  input  dat_t           dz_i,
  input  logic [SHW-1:0] sh_i,
  input  logic           hyp_i,
  output dat_t           x_o,
  output dat_t           y_o,
  output dat_t           z_o
);
  dat_t xs, ys;

  always_comb begin
    xs = x_i >>> sh_i;
    ys = y_i >>> sh_i;
    if (!z_i[W-1]) begin
      x_o = hyp_i ? x_i + ys : x_i - ys;
      y_o = y_i + xs;
      z_o = z_i - dz_i;
    end else begin
      x_o = hyp_i ? x_i - ys : x_i + ys;
      y_o = y_i - xs;
      z_o = z_i + dz_i;
    end
  end
endmodule

// File: rtl/cordic_iter_seq.sv
module cordic_iter_seq
  import cordic_pkg::*;
#(
  parameter int ITERS = 16,
  parameter int SHW   = 5
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           mode_i,
  output logic           busy_o,
  output logic [SHW-1:0] sh_o,
  output logic           hyp_o,
  output logic           fin_o
);
  logic           busy_q, hyp_q, rep_q, fin_q, last, rep_now;
  logic [SHW-1:0] sh_q;

  always_comb begin
    rep_now = hyp_q && is_rep(int'(sh_q)) && !rep_q;
    last    = (int'(sh_q) == (hyp_q ? ITERS : ITERS - 1)) && !rep_now;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      hyp_q  <= 1'b0;
      rep_q  <= 1'b0;
      fin_q  <= 1'b0;
      sh_q   <= '0;
    end else begin
      fin_q <= busy_q && last;
      if (start_i && !busy_q) begin
        busy_q <= 1'b1;
        hyp_q  <= mode_i;
        rep_q  <= 1'b0;
        sh_q   <= mode_i ? SHW'(1) : '0;
      end else if (busy_q) begin
        if (last) begin
          busy_q <= 1'b0;
        end else if (rep_now) begin
          rep_q <= 1'b1;
        end else begin
          rep_q <= 1'b0;
          sh_q  <= sh_q + SHW'(1);
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign sh_o   = sh_q;
  assign hyp_o  = hyp_q;
  assign fin_o  = fin_q;
endmodule

// File: rtl/cordic_rot_engine.sv
module cordic_rot_engine
  import cordic_pkg::*;
#(
  parameter int ITERS = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             mode_i,
  input  logic [ANG_W-1:0] angle_i,
  input  logic [ANG_W-1:0] hyp_arg_i,
  output logic signed [W-1:0] x_o,
  output logic signed [W-1:0] y_o,
  output logic signed [W-1:0] sum_o,
  output logic             done_o
);
  localparam int SHW   = $clog2(ITERS + 1);
  localparam int DEPTH = ITERS + 1;

  logic           busy, hyp, fin, flip0, flip_q, accept;
  logic [SHW-1:0] sh;
  dat_t           x0, z0, dz, nx, ny, nz;
  dat_t           x_q, y_q, z_q, xc, yc;
  dat_t           x_out, y_out, s_out;
  logic           done_q;

  cordic_iter_seq #(.ITERS(ITERS), .SHW(SHW)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .mode_i (mode_i),
    .busy_o (busy),
    .sh_o   (sh),
    .hyp_o  (hyp),
    .fin_o  (fin)
  );

  cordic_arg_prep u_prep (
    .mode_i   (mode_i),
    .angle_i  (angle_i),
    .hyp_arg_i(hyp_arg_i),
    .x0_o     (x0),
    .z0_o     (z0),
    .flip_o   (flip0)
  );

  cordic_arc_rom #(.DEPTH(DEPTH), .SHW(SHW)) u_rom (
    .sh_i (sh),
    .hyp_i(hyp),
    .dz_o (dz)
  );

  cordic_step #(.SHW(SHW)) u_step (
    .x_i  (x_q),
    .y_i  (y_q),
    .z_i  (z_q),
    .dz_i (dz),
    .sh_i (sh),
    .hyp_i(hyp),
    .x_o  (nx),
    .y_o  (ny),
    .z_o  (nz)
  );

  assign accept = start_i && !busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q    <= '0;
      y_q    <= '0;
      z_q    <= '0;
      flip_q <= 1'b0;
    end else if (accept) begin
      x_q    <= x0;
      y_q    <= '0;
      z_q    <= z0;
      flip_q <= flip0;
    end else if (busy) begin
      x_q <= nx;
      y_q <= ny;
      z_q <= nz;
    end
  end

  always_comb begin
    xc = flip_q ? -x_q : x_q;
    yc = flip_q ? -y_q : y_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_out  <= '0;
      y_out  <= '0;
      s_out  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= fin;
      if (fin) begin
        x_out <= xc;
        y_out <= yc;
        s_out <= xc + yc;
      end
    end
  end

  assign x_o    = x_out;
  assign y_o    = y_out;
  assign sum_o  = s_out;
  assign done_o = done_q;
endmodule

// File: rtl/cordic_rot_checker.sv
module cordic_rot_checker
  import cordic_pkg::*;
#(
  parameter int ITERS = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             mode_i,
  input logic             busy_i,
  input logic             done_i,
  input logic signed [W-1:0] x_i,
  input logic signed [W-1:0] y_i,
  input logic signed [W-1:0] sum_i
);
  localparam int   LAT_C = ITERS + 1;
  localparam int   LAT_H = ITERS + rep_count(ITERS) + 1;
  localparam dat_t ONE   = dat_t'(1) <<< FRAC;
  localparam dat_t TOL   = dat_t'(1) <<< (FRAC - 14);

  logic [7:0] cnt;
  logic       hyp_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt   <= '0;
      hyp_c <= 1'b0;
    end else if (start_i && !busy_i) begin
      cnt   <= '0;
      hyp_c <= mode_i;
    end else if (cnt != 8'hFF) begin
      cnt <= cnt + 8'd1;
    end
  end

  AST_LAT_CIRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && !hyp_c |-> cnt == 8'(LAT_C)); // R5
  AST_LAT_HYP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && hyp_c |-> cnt == 8'(LAT_H)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i); // R7
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |-> $stable(x_i) && $stable(y_i) && $stable(sum_i)); // R8
  AST_CIRC_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && !hyp_c |-> (x_i <= ONE + TOL) && (x_i >= -(ONE + TOL))
                      && (y_i <= ONE + TOL) && (y_i >= -(ONE + TOL))); // R1
  AST_COSH_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && hyp_c |-> x_i >= ONE - TOL); // R3
endmodule

bind cordic_rot_engine cordic_rot_checker #(.ITERS(ITERS)) i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .mode_i (mode_i),
  .busy_i (busy),
  .done_i (done_o),
  .x_i    (x_o),
  .y_i    (y_o),
  .sum_i  (sum_o)
);

// File: tb/test_cordic_rot_engine.sv
module test_cordic_rot_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic mode = 1'b0;
  logic [31:0] angle = '0;
  logic [31:0] harg = '0;
  logic signed [33:0] x, y, s;
  logic done;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  cordic_rot_engine i_cordic_rot_engine (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .angle_i(angle), .hyp_arg_i(harg),
    .x_o(x), .y_o(y), .sum_o(s), .done_o(done)
  );

  // mode, argument, expected x / y / sum in millionths
  localparam int NV = 11;
  localparam logic [128:0] VEC [NV] = '{
    {1'b0, 32'h00000000, 32'sd1000000, 32'sd0,         32'sd1000000},
    {1'b0, 32'h20000000, 32'sd707107,  32'sd707107,    32'sd1414214},
    {1'b0, 32'h40000000, 32'sd0,       32'sd1000000,   32'sd1000000},
    {1'b0, 32'h55555555, -32'sd500000, 32'sd866025,    32'sd366025},
    {1'b0, 32'h80000000, -32'sd1000000, 32'sd0,        -32'sd1000000},
    {1'b0, 32'hC0000000, 32'sd0,       -32'sd1000000,  -32'sd1000000},
    {1'b0, 32'hEAAAAAAB, 32'sd866025,  -32'sd500000,   32'sd366025},
    {1'b1, 32'h00000000, 32'sd1000000, 32'sd0,         32'sd1000000},
    {1'b1, 32'h10000000, 32'sd1031413, 32'sd252612,    32'sd1284025},
    {1'b1, 32'h20000000, 32'sd1127626, 32'sd521095,    32'sd1648721},
    {1'b1, 32'h40000000, 32'sd1543081, 32'sd1175201,   32'sd2718282}
  };

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog (all): cycles=%0d expected below %0d", cyc, 100000);
      summary();
      $finish;
    end
  end

  task automatic check_val(string tag, string what, logic signed [33:0] act, int micro, real tol);
    real e, a;
    e = real'(micro) * 1073741824.0 / 1.0e6;
    a = real'(act);
    checks++;
    if ((a - e) > tol * 1073741824.0 || (e - a) > tol * 1073741824.0) begin
      errors++;
      $display("FAIL %s %s: actual=%f expected=%f", tag, what, a / 1073741824.0, e / 1073741824.0);
    end
  endtask

  task automatic check_eq(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic run_op(bit m, logic [31:0] arg, output int lat);
    @(negedge clk);
    start = 1'b1;
    mode  = m;
    if (m) harg = arg; else angle = arg;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (lat < 200) begin
      @(negedge clk);
      lat++;
      if (done) break;
    end
  endtask

  initial begin
    int lat;
    logic signed [33:0] hx;

    // R10: reset state
    repeat (3) @(negedge clk);
    check_eq("R10", "done in reset", done, 0);
    check_eq("R10", "x in reset", x, 0);
    check_eq("R10", "sum in reset", s, 0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      logic [128:0] e;
      e = VEC[v];
      run_op(e[128], e[127:96], lat);
      if (!e[128]) begin
        check_eq("R5", "circular latency", lat, 17);
        check_val(v >= 2 ? "R2" : "R1", "cos", x, int'(signed'(e[95:64])), 2.0e-4);
        check_val(v >= 2 ? "R2" : "R1", "sin", y, int'(signed'(e[63:32])), 2.0e-4);
      end else begin
        check_eq("R6", "hyperbolic latency", lat, 19);
        check_val("R3", "cosh", x, int'(signed'(e[95:64])), 2.0e-4);
        check_val("R3", "sinh", y, int'(signed'(e[63:32])), 2.0e-4);
      end
      check_val("R4", "sum", s, int'(signed'(e[31:0])), 4.0e-4);
      check_eq("R4", "sum equals x+y", longint'(s), longint'(x) + longint'(y));
      @(negedge clk);
      check_eq("R7", "done after one cycle", done, 0);
    end

    // R8: outputs hold while inputs wander without a start
    hx = x;
    angle = 32'h12345678;
    harg  = 32'h3000000;
    mode  = 1'b1;
    repeat (6) @(negedge clk);
    check_eq("R8", "x held", x, hx);
    check_eq("R8", "done stays low", done, 0);

    // R9: start during a running computation is ignored
    @(negedge clk);
    start = 1'b1; mode = 1'b0; angle = 32'h00000000;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (lat < 200) begin
      @(negedge clk);
      lat++;
      if (lat == 3) begin
        start = 1'b1; mode = 1'b1; angle = 32'h80000000; harg = 32'h40000000;
      end else begin
        start = 1'b0;
      end
      if (done) break;
    end
    check_eq("R9", "latency unaffected", lat, 17);
    check_val("R9", "cos kept from first start", x, 1000000, 2.0e-4);
    check_val("R9", "sin kept from first start", y, 0, 2.0e-4);

    // R8: a result computed right after holds its new value
    run_op(1'b0, 32'h80000000, lat);
    check_val("R2", "cos 180 after reuse", x, -1000000, 2.0e-4);

    summary();
    $finish;
  end
endmodule